// File: doc/BRIEF.md
# Open-Row-Preferring Request Scheduler

This block sits in front of a single DRAM bank controller and holds read requests in a small reordering window until the controller can take one. Each request carries a row, a column and a tag. When the controller signals that it can accept work, the scheduler removes one request from the window and presents it on a registered dispatch port.

The scheduler remembers which row it last sent, and treats that row as the open row. In the row-preferring mode it searches the whole window for a request to that row, so requests to one row leave back to back as a run of hits, ahead of older requests that would miss. Each entry has an age counter, so a request that keeps losing to hits is forced out once it has waited long enough. In the plain mode the window behaves as a first-in first-out queue. The mode input selects between the two, and may change only while the window is empty.

Top module: `row_hit_sched`

## Requirements
- R1: The window holds at most DEPTH requests. `enq_ready` is high exactly when fewer than DEPTH entries are held. A request is stored on a clock edge where `enq_valid` and `enq_ready` are both high.
- R2: With `mode_hit_first` low, requests are dispatched strictly in the order they were stored.
- R3: With `mode_hit_first` high and no aged entry, if any held entry has the open row, the oldest such entry is dispatched, even when older entries would miss.
- R4: With `mode_hit_first` high, no aged entry and no entry on the open row, the oldest entry is dispatched.
- R5: After reset no row is open. Each dispatch makes the dispatched row the open row.
- R6: An entry's age starts at 0 on the edge that stores it. It grows by one on every later edge it stays held, and saturates at AGE_LIMIT. With `mode_hit_first` high, an entry whose age has reached AGE_LIMIT wins over hits, the oldest such entry first.
- R7: On an edge where `ctrl_ready` is high and the window is not empty, exactly one entry is removed. The next cycle shows `disp_valid` high for one cycle, with that entry's row, column and tag. Otherwise `disp_valid` is low.
- R8: A store and a dispatch on the same edge are both carried out, so the occupancy stays unchanged.
- R9: `mode_hit_first` changes only on cycles when the window is empty or becomes non-empty by that edge's store.
- R10: While `rst` is high and on the cycle after, `disp_valid` is low and `enq_ready` is high.
- R11: `disp_hit` is high with a dispatch exactly when the dispatched row equals the row that was open before that dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_hit_first | input | 1 | 1: prefer open-row hits; 0: arrival order |
| enq_valid | input | 1 | A request is offered |
| enq_ready | output | 1 | Window has a free entry |
| enq_row | input | ROW_W | Row of the offered request |
| enq_col | input | COL_W | Column of the offered request |
| enq_tag | input | TAG_W | Tag of the offered request |
| ctrl_ready | input | 1 | Bank controller can take a request this cycle |
| disp_valid | output | 1 | A request is being dispatched |
| disp_row | output | ROW_W | Row of the dispatched request |
| disp_col | output | COL_W | Column of the dispatched request |
| disp_tag | output | TAG_W | Tag of the dispatched request |
| disp_hit | output | 1 | The dispatched request hit the open row |

## Verification
The bench builds the scheduler with a four-entry window, three-bit rows and an age limit of six. With these values the window fills and overflows within a few cycles, and the age cap fires after six waiting cycles, inside a short directed run. A reference model in the bench follows every cycle of a long pseudo-random run in each mode. The rows are drawn from only four values, so hits, misses, full-window stalls and same-edge store-and-dispatch all occur densely. Directed cases fix the expected tag order for reordering, for arrival order, and for an entry forced out by age.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Reason an entry was selected for dispatch.
  typedef enum logic [1:0] {
    PICK_OLDEST = 2'd0,
    PICK_HIT    = 2'd1,
    PICK_AGED   = 2'd2
  } pick_e;
endpackage

// File: rtl/sched_pick.sv
// Finds the lowest set bit (lowest index = oldest entry).
module sched_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sched_match.sv
// Per-entry hit and age-limit flags for the held entries.
module sched_match #(
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 14,
  parameter int AGE_LIMIT = 31,
  parameter int AGE_W     = $clog2(AGE_LIMIT + 1),
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][ROW_W-1:0] rows,
  input  logic [DEPTH-1:0][AGE_W-1:0] ages,
  input  logic [CNT_W-1:0]            cnt,
  input  logic                        open_valid,
  input  logic [ROW_W-1:0]            open_row,
  output logic [DEPTH-1:0]            hit_vec,
  output logic [DEPTH-1:0]            aged_vec
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic held;
    assign held        = CNT_W'(g) < cnt;
    assign hit_vec[g]  = held && open_valid && (rows[g] == open_row);
    assign aged_vec[g] = held && (ages[g] >= AGE_W'(AGE_LIMIT));
  end
endmodule

// File: rtl/sched_window.sv
// Collapsing window: index 0 is always the oldest entry.
module sched_window #(
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TAG_W     = 8,
  parameter int AGE_LIMIT = 31,
  parameter int AGE_W     = $clog2(AGE_LIMIT + 1),
  parameter int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [ROW_W-1:0]            push_row,
  input  logic [COL_W-1:0]            push_col,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic                        pop,
  input  logic [IDX_W-1:0]            pop_idx,
  output logic [DEPTH-1:0][ROW_W-1:0] rows,
  output logic [DEPTH-1:0][COL_W-1:0] cols,
  output logic [DEPTH-1:0][TAG_W-1:0] tags,
  output logic [DEPTH-1:0][AGE_W-1:0] ages,
  output logic [CNT_W-1:0]            cnt
);
  logic [DEPTH-1:0][ROW_W-1:0] row_q, row_n;
  logic [DEPTH-1:0][COL_W-1:0] col_q, col_n;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_n;
  logic [DEPTH-1:0][AGE_W-1:0] age_q, age_n;
  logic [CNT_W-1:0]            cnt_q, cnt_n, base;
  logic [IDX_W-1:0]            sel;
  logic [AGE_W-1:0]            a;

  always_comb begin
    base  = pop ? cnt_q - CNT_W'(1) : cnt_q;
    cnt_n = base + CNT_W'(push);
    row_n = row_q;
    col_n = col_q;
    tag_n = tag_q;
    age_n = age_q;
    sel   = '0;
    a     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      sel = IDX_W'(i);
      if (pop && (IDX_W'(i) >= pop_idx) && (i < DEPTH - 1)) sel = IDX_W'(i + 1);
      a        = age_q[sel];
      row_n[i] = row_q[sel];
      col_n[i] = col_q[sel];
      tag_n[i] = tag_q[sel];
      age_n[i] = (a == AGE_W'(AGE_LIMIT)) ? a : a + AGE_W'(1);
      if (push && (CNT_W'(i) == base)) begin
        row_n[i] = push_row;
        col_n[i] = push_col;
        tag_n[i] = push_tag;
        age_n[i] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      age_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      age_q <= age_n;
    end
    row_q <= row_n;
    col_q <= col_n;
    tag_q <= tag_n;
  end

  assign rows = row_q;
  assign cols = col_q;
  assign tags = tag_q;
  assign ages = age_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/row_hit_sched.sv
module row_hit_sched #(
  parameter int DEPTH     = 8,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 10,
  parameter int TAG_W     = 8,
  parameter int AGE_LIMIT = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_hit_first,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [ROW_W-1:0] enq_row,
  input  logic [COL_W-1:0] enq_col,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic             ctrl_ready,
  output logic             disp_valid,
  output logic [ROW_W-1:0] disp_row,
  output logic [COL_W-1:0] disp_col,
  output logic [TAG_W-1:0] disp_tag,
  output logic             disp_hit
);
  import sched_pkg::*;

  localparam int AGE_W = $clog2(AGE_LIMIT + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ROW_W-1:0] rows;
  logic [DEPTH-1:0][COL_W-1:0] cols;
  logic [DEPTH-1:0][TAG_W-1:0] tags;
  logic [DEPTH-1:0][AGE_W-1:0] ages;
  logic [CNT_W-1:0]            cnt;
  logic [DEPTH-1:0]            hit_vec, aged_vec;
  logic                        hit_any, aged_any;
  logic [IDX_W-1:0]            hit_idx, aged_idx, pick_idx;
  logic                        open_valid;
  logic [ROW_W-1:0]            open_row;
  logic                        do_push, do_pop;
  pick_e                       why;

  assign enq_ready = cnt != CNT_W'(DEPTH);
  assign do_push   = enq_valid && enq_ready;
  assign do_pop    = ctrl_ready && (cnt != '0);

  sched_window #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
    .AGE_LIMIT(AGE_LIMIT), .AGE_W(AGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_win (
    .clk(clk), .rst(rst),
    .push(do_push), .push_row(enq_row), .push_col(enq_col), .push_tag(enq_tag),
    .pop(do_pop), .pop_idx(pick_idx),
    .rows(rows), .cols(cols), .tags(tags), .ages(ages), .cnt(cnt)
  );

  sched_match #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .AGE_LIMIT(AGE_LIMIT), .AGE_W(AGE_W), .CNT_W(CNT_W)
  ) u_match (
    .rows(rows), .ages(ages), .cnt(cnt),
    .open_valid(open_valid), .open_row(open_row),
    .hit_vec(hit_vec), .aged_vec(aged_vec)
  );

  sched_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_hit (
    .req(hit_vec), .found(hit_any), .idx(hit_idx)
  );

  sched_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_aged (
    .req(aged_vec), .found(aged_any), .idx(aged_idx)
  );

  always_comb begin
    why = PICK_OLDEST;
    if (mode_hit_first) begin
      if (aged_any)     why = PICK_AGED;
      else if (hit_any) why = PICK_HIT;
    end
    case (why)
      PICK_AGED: pick_idx = aged_idx;
      PICK_HIT:  pick_idx = hit_idx;
      default:   pick_idx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_row   <= '0;
      disp_col   <= '0;
      disp_tag   <= '0;
      disp_hit   <= 1'b0;
      open_valid <= 1'b0;
      open_row   <= '0;
    end else begin
      disp_valid <= do_pop;
      if (do_pop) begin
        disp_row   <= rows[pick_idx];
        disp_col   <= cols[pick_idx];
        disp_tag   <= tags[pick_idx];
        disp_hit   <= hit_vec[pick_idx];
        open_valid <= 1'b1;
        open_row   <= rows[pick_idx];
      end
    end
  end
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_hit_first,
  input logic             enq_valid,
  input logic             enq_ready,
  input logic             ctrl_ready,
  input logic [CNT_W-1:0] cnt,
  input logic             hit_any,
  input logic             aged_any,
  input logic             disp_valid,
  input logic             disp_hit
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R1
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(DEPTH)) |-> !enq_ready);

  // R7
  disp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> ($past(ctrl_ready) && ($past(cnt) != '0)));

  // R7
  disp_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_ready && (cnt != '0)) |=> disp_valid);

  // R3
  hit_pref_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_ready && (cnt != '0) && mode_hit_first && hit_any && !aged_any) |=> disp_hit);

  // R11
  miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_ready && (cnt != '0) && !hit_any) |=> !disp_hit);

  // R8
  both_ways_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_ready && (cnt != '0) && enq_valid && enq_ready) |=> (cnt == $past(cnt)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt != '0) && ($past(cnt) != '0)) |-> $stable(mode_hit_first));
endmodule

bind row_hit_sched sched_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mode_hit_first(mode_hit_first),
  .enq_valid(enq_valid), .enq_ready(enq_ready), .ctrl_ready(ctrl_ready),
  .cnt(cnt), .hit_any(hit_any), .aged_any(aged_any),
  .disp_valid(disp_valid), .disp_hit(disp_hit)
);

// File: tb/tb_row_hit_sched.sv
module tb_row_hit_sched;
  localparam int DEPTH = 4, ROW_W = 3, COL_W = 4, TAG_W = 6, AGE_LIMIT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             mode_hit_first = 1'b0;
  logic             enq_valid = 1'b0, ctrl_ready = 1'b0;
  logic [ROW_W-1:0] enq_row = '0;
  logic [COL_W-1:0] enq_col = '0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic             enq_ready, disp_valid, disp_hit;
  logic [ROW_W-1:0] disp_row;
  logic [COL_W-1:0] disp_col;
  logic [TAG_W-1:0] disp_tag;

  row_hit_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W),
                  .AGE_LIMIT(AGE_LIMIT)) dut (
    .clk(clk), .rst(rst), .mode_hit_first(mode_hit_first),
    .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_row(enq_row), .enq_col(enq_col), .enq_tag(enq_tag),
    .ctrl_ready(ctrl_ready), .disp_valid(disp_valid),
    .disp_row(disp_row), .disp_col(disp_col), .disp_tag(disp_tag), .disp_hit(disp_hit)
  );

  int tests = 0, fails = 0;
  int m_cnt;
  int m_row[DEPTH], m_col[DEPTH], m_tag[DEPTH], m_age[DEPTH];
  bit m_open_v;
  int m_open;
  bit e_valid, e_hit;
  int e_row, e_col, e_tag;
  string e_req = "R7";
  int tag_ctr = 0;
  int got[64];
  int ngot = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit ev, input int row, input int col, input bit cr);
    bit acc;
    acc = ev && (m_cnt < DEPTH);
    e_valid = cr && (m_cnt > 0);
    if (e_valid) begin
      int pk, ag, ht;
      pk = 0; ag = -1; ht = -1;
      if (mode_hit_first) begin
        for (int i = m_cnt - 1; i >= 0; i--) begin
          if (m_age[i] >= AGE_LIMIT) ag = i;
          if (m_open_v && m_row[i] == m_open) ht = i;
        end
        if (ag >= 0) pk = ag;
        else if (ht >= 0) pk = ht;
      end
      e_row = m_row[pk]; e_col = m_col[pk]; e_tag = m_tag[pk];
      e_hit = m_open_v && (m_row[pk] == m_open);
      m_open_v = 1'b1; m_open = m_row[pk];
      for (int i = pk; i < m_cnt - 1; i++) begin
        m_row[i] = m_row[i+1]; m_col[i] = m_col[i+1];
        m_tag[i] = m_tag[i+1]; m_age[i] = m_age[i+1];
      end
      m_cnt--;
    end
    for (int i = 0; i < m_cnt; i++) if (m_age[i] < AGE_LIMIT) m_age[i]++;
    if (acc) begin
      m_row[m_cnt] = row; m_col[m_cnt] = col; m_tag[m_cnt] = tag_ctr; m_age[m_cnt] = 0;
      m_cnt++;
      tag_ctr = (tag_ctr + 1) % 64;
    end
  endtask

  // One cycle: check last cycle's dispatch, drive new inputs, advance the model.
  task automatic cyc(input bit ev, input int row, input int col, input bit cr, input string req);
    @(negedge clk);
    check(disp_valid === e_valid, e_req, "disp_valid", int'(disp_valid), int'(e_valid));
    if (e_valid && disp_valid === 1'b1) begin
      check(int'(disp_tag) == e_tag, e_req, "disp_tag", int'(disp_tag), e_tag);
      check(int'(disp_row) == e_row && int'(disp_col) == e_col, "R7", "disp_row", int'(disp_row), e_row);
      check(disp_hit === e_hit, "R11", "disp_hit", int'(disp_hit), int'(e_hit));
      if (ngot < 64) begin got[ngot] = int'(disp_tag); ngot++; end
    end
    enq_valid = ev; enq_row = ROW_W'(row); enq_col = COL_W'(col);
    enq_tag = TAG_W'(tag_ctr); ctrl_ready = cr;
    check(enq_ready === (m_cnt < DEPTH), "R1", "enq_ready", int'(enq_ready), int'(m_cnt < DEPTH));
    model_step(ev, row, col, cr);
    e_req = req;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enq_valid = 1'b0; ctrl_ready = 1'b0;
    @(negedge clk);
    // R10
    check(disp_valid === 1'b0, "R10", "disp_valid in reset", int'(disp_valid), 0);
    check(enq_ready === 1'b1, "R10", "enq_ready in reset", int'(enq_ready), 1);
    rst = 1'b0;
    m_cnt = 0; m_open_v = 1'b0; m_open = 0; e_valid = 1'b0; ngot = 0;
  endtask

  task automatic drain();
    while (m_cnt > 0) cyc(1'b0, 0, 0, 1'b1, "R9");
    cyc(1'b0, 0, 0, 1'b0, "R9");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    // R2: arrival order with rows 1,2,1,2
    mode_hit_first = 1'b0;
    do_reset();
    base = tag_ctr;
    cyc(1, 1, 0, 0, "R2"); cyc(1, 2, 1, 0, "R2"); cyc(1, 1, 2, 0, "R2"); cyc(1, 2, 3, 0, "R2");
    cyc(1, 3, 4, 0, "R1");  // window full: refused
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, "R2");
    cyc(0, 0, 0, 0, "R2");
    for (int k = 0; k < 4; k++) check(got[k] == (base + k) % 64, "R2", "fcfs order", got[k], (base + k) % 64);

    // R3 / R4 / R5: same pattern, row-preferring mode
    mode_hit_first = 1'b1;
    do_reset();
    base = tag_ctr;
    cyc(1, 1, 0, 0, "R3"); cyc(1, 2, 1, 0, "R3"); cyc(1, 1, 2, 0, "R3"); cyc(1, 2, 3, 0, "R3");
    cyc(0, 0, 0, 1, "R5"); cyc(0, 0, 0, 1, "R3"); cyc(0, 0, 0, 1, "R4"); cyc(0, 0, 0, 1, "R3");
    cyc(0, 0, 0, 0, "R3");
    check(got[0] == base,            "R5", "first after reset", got[0], base);
    check(got[1] == (base + 2) % 64, "R3", "hit jumps ahead",   got[1], (base + 2) % 64);
    check(got[2] == (base + 1) % 64, "R4", "oldest on miss",    got[2], (base + 1) % 64);
    check(got[3] == (base + 3) % 64, "R3", "hit after switch",  got[3], (base + 3) % 64);

    // R6: a row-2 request starved by row-5 hits leaves after AGE_LIMIT edges
    do_reset();
    base = tag_ctr;
    cyc(1, 5, 0, 0, "R6"); cyc(1, 2, 1, 0, "R6");
    for (int k = 0; k < 10; k++) cyc(1, 5, k, 1, "R6");
    drain();
    check(got[6] == (base + 1) % 64, "R6", "aged entry position", got[6], (base + 1) % 64);

    // Pseudo-random runs in both modes (R8: stores and dispatches overlap)
    for (int md = 0; md < 2; md++) begin
      mode_hit_first = md[0];
      do_reset();
      for (int k = 0; k < 3000; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[0], int'(lfsr[3:2]), int'(lfsr[7:4]), lfsr[9] | lfsr[11],
            md == 1 ? "R3" : "R8");
      end
      drain();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule